// File: doc/BRIEF.md
# Cache line read burst sequencer

The block sits between a wide cache data array and a 64-bit response port. When a hit request is accepted, it reads the array 256 bits per access. It then streams the selected 256-bit segment to the requester as four 64-bit beats. The first beat leaves after a fixed latency, which is set at build time by whether the array has an extra pipeline stage. The other three beats follow on consecutive clocks.

The line size is a parameter with two legal values, 32 bytes and 64 bytes. A 32-byte line fills exactly one array access. A 64-byte line takes two array accesses, and only the 256-bit half that holds the requested byte address is returned. The block holds one request at a time. The requester presents a byte address and a tag, waits for `ready_o`, and matches the returned beats to the request through the echoed tag. The array is a behavioural model with computed contents.

Top module: `cl_burst_seq`

## Requirements
- R1: While reset is active and after it is released, `ready_o` is 1 and `beat_valid_o` is 0.
- R2: A request is accepted on a rising clock edge where `req_valid_i` and `ready_o` are both 1. From that edge until the edge that retires the last beat, `ready_o` stays 0.
- R3: The first beat is valid right after the 9th rising edge following the accepting edge when `PIPE_ARRAY` is 0, and after the 10th when `PIPE_ARRAY` is 1.
- R4: Every burst is exactly four beats on consecutive clocks. `beat_idx_o` counts 0, 1, 2, 3, and `beat_last_o` is 1 only on index 3.
- R5: Beat i carries 64-bit word i (bits 64i+63:64i) of one 256-bit array segment. For 32-byte lines this is segment 0 of line `addr>>5`. For 64-byte lines it is segment `addr[5]` of line `addr>>6`. Word d of segment s of line L is {16'h0000, L[15:0], 16'hA5A5, s as 8 bits, d as 8 bits}.
- R6: `beat_tag_o` equals the tag presented with the accepted request on all four beats.
- R7: A request presented while `ready_o` is 0 is ignored: it produces no beats and does not change the burst in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | ADDR_W | Byte address of the requested data |
| req_tag_i | input | TAG_W | Requester tag |
| ready_o | output | 1 | Block is idle and can accept a request |
| beat_valid_o | output | 1 | Beat present on the data outputs |
| beat_data_o | output | 64 | Beat data |
| beat_idx_o | output | 2 | Word index of the beat within the segment |
| beat_last_o | output | 1 | Final beat of the burst |
| beat_tag_o | output | TAG_W | Echoed requester tag |

## Verification
A latency counter preloaded with the wrong value shows up on the very first burst. The first beat leaves one or more cycles early or late, and the burst position check reports it. Segment selection is checked by data that encodes the line, the segment and the word index, so a wrong half-select or wrong beat ordering appears on the first beat whose pattern differs. A wrong state bit that lets a busy request through appears as extra beats that have no matching entry in the scoreboard.

// File: rtl/cl_burst_pkg.sv
package cl_burst_pkg;
  localparam int unsigned BEAT_W = 64;
  localparam int unsigned ARR_W  = 256;
  localparam int unsigned BEATS  = ARR_W / BEAT_W;
  localparam int unsigned IDX_W  = $clog2(BEATS);

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} seq_st_e;

  // behavioural array content
  function automatic logic [BEAT_W-1:0] fill_dw(logic [15:0] line, logic [7:0] seg, logic [7:0] dw);
    return {16'h0000, line, 16'hA5A5, seg, dw};
  endfunction
endpackage

// File: rtl/cl_array_model.sv
module cl_array_model
  import cl_burst_pkg::*;
#(
  parameter int unsigned LINE_IW = 18,
  parameter int unsigned SEG_W   = 1,
  parameter int unsigned STAGES  = 1
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rd_en_i,
  input  logic [LINE_IW-1:0]             rd_line_i,
  input  logic [SEG_W-1:0]               rd_seg_i,
  output logic                           rvalid_o,
  output logic [SEG_W-1:0]               rseg_o,
  output logic [BEATS-1:0][BEAT_W-1:0]   rdata_o
);
  logic [BEATS-1:0][BEAT_W-1:0] word_d, s1_data_q;
  logic                         s1_v_q;
  logic [SEG_W-1:0]             s1_seg_q;

  always_comb begin
    for (int d = 0; d < int'(BEATS); d++)
      word_d[d] = fill_dw(16'(rd_line_i), 8'(rd_seg_i), 8'(d));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v_q    <= 1'b0;
      s1_seg_q  <= '0;
      s1_data_q <= '0;
    end else begin
      s1_v_q <= rd_en_i;
      if (rd_en_i) begin
        s1_seg_q  <= rd_seg_i;
        s1_data_q <= word_d;
      end
    end
  end

  generate
    if (STAGES > 1) begin : g_pipe
      logic                         s2_v_q;
      logic [SEG_W-1:0]             s2_seg_q;
      logic [BEATS-1:0][BEAT_W-1:0] s2_data_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s2_v_q    <= 1'b0;
          s2_seg_q  <= '0;
          s2_data_q <= '0;
        end else begin
          s2_v_q    <= s1_v_q;
          s2_seg_q  <= s1_seg_q;
          s2_data_q <= s1_data_q;
        end
      end
      assign rvalid_o = s2_v_q;
      assign rseg_o   = s2_seg_q;
      assign rdata_o  = s2_data_q;
    end else begin : g_flat
      assign rvalid_o = s1_v_q;
      assign rseg_o   = s1_seg_q;
      assign rdata_o  = s1_data_q;
    end
  endgenerate
endmodule

// File: rtl/cl_burst_ctrl.sv
module cl_burst_ctrl
  import cl_burst_pkg::*;
#(
  parameter int unsigned LAT   = 9,
  parameter int unsigned NSEG  = 2,
  parameter int unsigned SEG_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              ready_o,
  output logic              accept_o,
  output logic              rd_en_o,
  output logic [SEG_W-1:0]  rd_seg_o,
  output logic              beat_valid_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic              beat_last_o
);
  localparam int unsigned CNT_W = $clog2(LAT);
  localparam int unsigned RL_W  = $clog2(NSEG + 1);

  seq_st_e            st_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q;
  logic [RL_W-1:0]    rd_left_q;
  logic [SEG_W-1:0]   rd_seg_q;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept_o = req_valid_i & ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      rd_left_q <= '0;
      rd_seg_q  <= '0;
    end else begin
      if (accept_o) begin
        rd_left_q <= RL_W'(NSEG);
        rd_seg_q  <= '0;
      end else if (rd_left_q != '0) begin
        rd_left_q <= rd_left_q - 1'b1;
        rd_seg_q  <= rd_seg_q + 1'b1;
      end
      unique case (st_q)
        ST_IDLE: if (accept_o) begin
          st_q  <= ST_WAIT;
          cnt_q <= CNT_W'(LAT - 1);
        end
        ST_WAIT: if (cnt_q == '0) begin
          st_q  <= ST_BURST;
          idx_q <= '0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_BURST: if (idx_q == IDX_W'(BEATS - 1)) st_q <= ST_IDLE;
                  else idx_q <= idx_q + 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o      = (rd_left_q != '0);
  assign rd_seg_o     = rd_seg_q;
  assign beat_valid_o = (st_q == ST_BURST);
  assign beat_idx_o   = idx_q;
  assign beat_last_o  = (st_q == ST_BURST) && (idx_q == IDX_W'(BEATS - 1));

  AST_READS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !rd_en_o); // R5
  AST_WAIT_NO_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT) |-> !beat_valid_o && !ready_o); // R2
endmodule

// File: rtl/cl_line_buf.sv
module cl_line_buf
  import cl_burst_pkg::*;
#(
  parameter int unsigned SEG_W = 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          rvalid_i,
  input  logic [SEG_W-1:0]              rseg_i,
  input  logic [BEATS-1:0][BEAT_W-1:0]  rdata_i,
  input  logic [SEG_W-1:0]              sel_seg_i,
  input  logic [IDX_W-1:0]              beat_idx_i,
  output logic [BEAT_W-1:0]             beat_data_o
);
  logic [BEATS-1:0][BEAT_W-1:0] buf_q;

  // keep only the segment that holds the requested address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             buf_q <= '0;
    else if (rvalid_i && rseg_i == sel_seg_i) buf_q <= rdata_i;
  end

  assign beat_data_o = buf_q[beat_idx_i];
endmodule

// File: rtl/cl_burst_seq.sv
module cl_burst_seq
  import cl_burst_pkg::*;
#(
  parameter int unsigned LINE_BYTES = 64,
  parameter bit          PIPE_ARRAY = 1'b0,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned TAG_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  output logic              ready_o,
  output logic              beat_valid_o,
  output logic [63:0]       beat_data_o,
  output logic [1:0]        beat_idx_o,
  output logic              beat_last_o,
  output logic [TAG_W-1:0]  beat_tag_o
);
  localparam int unsigned SEG_BYTES = ARR_W / 8;
  localparam int unsigned NSEG      = LINE_BYTES / SEG_BYTES;
  localparam int unsigned SEG_W     = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES);
  localparam int unsigned SOFS_W    = $clog2(SEG_BYTES);
  localparam int unsigned LINE_IW   = ADDR_W - OFS_W;
  localparam int unsigned LAT       = PIPE_ARRAY ? 10 : 9;
  localparam int unsigned STAGES    = PIPE_ARRAY ? 2 : 1;

  logic                         accept;
  logic                         rd_en;
  logic [SEG_W-1:0]             rd_seg, rseg, req_seg, sel_q;
  logic                         rvalid;
  logic [BEATS-1:0][BEAT_W-1:0] rdata;
  logic [LINE_IW-1:0]           line_q;
  logic [TAG_W-1:0]             tag_q;
  logic                         addr_lo_unused;

  assign addr_lo_unused = ^req_addr_i[SOFS_W-1:0];

  generate
    if (NSEG > 1) begin : g_two_seg
      assign req_seg = req_addr_i[OFS_W-1:SOFS_W];
    end else begin : g_one_seg
      assign req_seg = '0;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      sel_q  <= '0;
      tag_q  <= '0;
    end else if (accept) begin
      line_q <= req_addr_i[ADDR_W-1:OFS_W];
      sel_q  <= req_seg;
      tag_q  <= req_tag_i;
    end
  end

  cl_burst_ctrl #(.LAT(LAT), .NSEG(NSEG), .SEG_W(SEG_W)) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i,
    .ready_o, .accept_o(accept),
    .rd_en_o(rd_en), .rd_seg_o(rd_seg),
    .beat_valid_o, .beat_idx_o, .beat_last_o
  );

  cl_array_model #(.LINE_IW(LINE_IW), .SEG_W(SEG_W), .STAGES(STAGES)) u_array (
    .clk_i, .rst_ni,
    .rd_en_i(rd_en), .rd_line_i(line_q), .rd_seg_i(rd_seg),
    .rvalid_o(rvalid), .rseg_o(rseg), .rdata_o(rdata)
  );

  cl_line_buf #(.SEG_W(SEG_W)) u_buf (
    .clk_i, .rst_ni,
    .rvalid_i(rvalid), .rseg_i(rseg), .rdata_i(rdata),
    .sel_seg_i(sel_q), .beat_idx_i(beat_idx_o),
    .beat_data_o
  );

  assign beat_tag_o = tag_q;

  AST_FIRST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(beat_valid_o) |-> $past(accept, LAT + 1)); // R3
  AST_FIRST_IDX_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(beat_valid_o) |-> beat_idx_o == 2'd0); // R4
  AST_BEATS_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_last_o |=> beat_valid_o && beat_idx_o == $past(beat_idx_o) + 2'd1); // R4
  AST_END_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && beat_last_o |=> !beat_valid_o && ready_o); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o |-> !ready_o); // R2
  AST_TAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat_valid_o && !beat_last_o |=> $stable(beat_tag_o)); // R6
  AST_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(beat_tag_o)); // R7
endmodule

// File: tb/cl_burst_seq_tb_top.sv
module cl_burst_seq_tb_top;
  localparam int ADDR_W = 24;
  localparam int TAG_W  = 4;
  localparam int LAT_A  = 9;   // 64-byte lines, flat array
  localparam int LAT_B  = 10;  // 32-byte lines, pipelined array

  typedef struct {
    logic [63:0]      d;
    logic [1:0]       i;
    logic             l;
    logic [TAG_W-1:0] t;
    int               c;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [TAG_W-1:0]  req_tag = '0;

  logic a_ready, a_bv, a_last, b_ready, b_bv, b_last;
  logic [63:0] a_data, b_data;
  logic [1:0]  a_idx, b_idx;
  logic [TAG_W-1:0] a_tag, b_tag;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  exp_t qa[$];
  exp_t qb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cl_burst_seq #(.LINE_BYTES(64), .PIPE_ARRAY(1'b0), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr), .req_tag_i(req_tag),
    .ready_o(a_ready), .beat_valid_o(a_bv), .beat_data_o(a_data), .beat_idx_o(a_idx),
    .beat_last_o(a_last), .beat_tag_o(a_tag));

  cl_burst_seq #(.LINE_BYTES(32), .PIPE_ARRAY(1'b1), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr), .req_tag_i(req_tag),
    .ready_o(b_ready), .beat_valid_o(b_bv), .beat_data_o(b_data), .beat_idx_o(b_idx),
    .beat_last_o(b_last), .beat_tag_o(b_tag));

  function automatic logic [63:0] pat(logic [15:0] line, logic [7:0] seg, logic [7:0] dw);
    return {16'h0000, line, 16'hA5A5, seg, dw};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [ADDR_W-1:0] a, logic [TAG_W-1:0] t);
    int acc;
    logic [ADDR_W-1:0] la, lb;
    @(negedge clk);
    while (!(a_ready && b_ready)) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_tag = t;
    @(negedge clk);
    acc = cyc;
    req_valid = 1'b0;
    chk("R2", "ready low after accept", {63'd0, a_ready | b_ready}, 64'd0);
    la = a >> 6;
    lb = a >> 5;
    for (int i = 0; i < 4; i++) begin
      qa.push_back('{pat(la[15:0], 8'(a[5]), 8'(i)), 2'(i), i == 3, t, acc + LAT_A + i});
      qb.push_back('{pat(lb[15:0], 8'd0, 8'(i)), 2'(i), i == 3, t, acc + LAT_B + i});
    end
  endtask

  task automatic mon(string who, ref exp_t q[$], input logic [63:0] d, input logic [1:0] i,
                     input logic l, input logic [TAG_W-1:0] t);
    exp_t e;
    if (q.size() == 0) begin
      checks++; failures++;
      $display("FAIL R7 %s unexpected beat actual_tag=%h expected=none", who, t);
      return;
    end
    e = q.pop_front();
    chk("R3", {who, " beat cycle"}, 64'(cyc), 64'(e.c));
    chk("R5", {who, " data"}, d, e.d);
    chk("R4", {who, " index"}, 64'(i), 64'(e.i));
    chk("R4", {who, " last"}, 64'(l), 64'(e.l));
    chk("R6", {who, " tag"}, 64'(t), 64'(e.t));
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (a_bv) mon("cfg64", qa, a_data, a_idx, a_last, a_tag);
      if (b_bv) mon("cfg32p", qb, b_data, b_idx, b_last, b_tag);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "ready in reset", {62'd0, a_ready, b_ready}, 64'd3);
    chk("R1", "valid in reset", {62'd0, a_bv, b_bv}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ready after reset", {62'd0, a_ready, b_ready}, 64'd3);
    chk("R1", "valid after reset", {62'd0, a_bv, b_bv}, 64'd0);

    send(24'h000000, 4'h1);
    send(24'h000020, 4'h2);   // upper half for 64-byte line
    send(24'h0012A4, 4'h3);
    send(24'hFFFFE0, 4'h4);
    send(24'h00ABCD, 4'h5);

    // R7: request while busy must be ignored
    send(24'h123460, 4'h6);
    @(negedge clk);
    req_valid = 1'b1; req_addr = 24'h0777C0; req_tag = 4'hF;
    repeat (3) @(negedge clk);
    chk("R2", "ready low while busy", {62'd0, a_ready, b_ready}, 64'd0);
    req_valid = 1'b0;

    send(24'h000040, 4'h7);   // back-to-back with preceding burst
    send(24'h3FFFFF, 4'h8);

    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    done = 1'b1;
    chk("R7", "no stray beats", {62'd0, a_bv, b_bv}, 64'd0);
    chk("R1", "idle at end", {62'd0, a_ready, b_ready}, 64'd3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule